// File: doc/BRIEF.md
# Indirect Nonvolatile Memory Access Controller

This block sits on a processor's special-function register bus. It gives software indirect access to two memories through a small set of byte registers. The first memory is a 256-byte data array that software can read and write one byte at a time. The second is a read-only program store of 14-bit words at 13-bit word addresses. The block reaches the program store through a synchronous read port. Software loads the address and data registers, then starts an operation by setting a go bit in the control register. Hardware clears that go bit when the operation is done.

A byte write is guarded twice. The write-permission bit must already be set, and the unlock register must have received a fixed two-value key just before the go request. The write first erases the byte to FFh, then stores the new value, and it holds the block busy for a fixed timed interval. When the write finishes, hardware raises a sticky completion flag. A warm reset that lands during a write cancels it and leaves a sticky error bit that software can read after the reset. Only a power-on reset or a software clear removes that error bit.

Top module: `nvm_access_ctrl`

## Requirements
- R1: After power-on reset, all six registers read 00h and `irq` is low.
- R2: The register indexes are 0 address-low, 1 address-high, 2 data-low, 3 data-high, 4 control and 5 key. The control bits are 0 read-go, 1 write-go, 2 write-permit, 3 write-error, 4 write-done and 7 program-select. Address-high keeps its low 5 bits and data-high keeps its low 6 bits; their upper bits read 0. A read started with program-select clear loads data-low from the data array at the address-low location. The read-go bit reads 1 for exactly one cycle after the control write.
- R3: A read started with program-select set pulses `pm_en` for one cycle with `pm_addr` = {address-high, address-low}. One cycle later the block captures `pm_data[13:8]` into data-high and `pm_data[7:0]` into data-low. Read-go reads 1 for exactly two cycles.
- R4: A write-go request made while program-select is set is not accepted. No memory location changes.
- R5: Writing 0 to read-go or write-go has no effect. These bits are cleared only by hardware, when the operation ends.
- R6: Setting write-go is accepted only when all of these hold: write-permit is already 1; the two bus writes just before it were 55h and then AAh to the key register; and the block is idle. Any other bus write in between cancels the key.
- R7: An accepted write holds write-go at 1 for exactly WR_CYCLES cycles (default 16). After that, the data-array byte holds the data-low value.
- R8: When a write ends, write-done and `irq` go to 1. Writing 0 to write-done clears it. Writing 1 to write-done never sets it.
- R9: A warm reset during a write sets write-error and clears the address and data registers. Write-error survives warm resets. It is cleared by power-on reset or by writing 0 to it.
- R10: The key register stores nothing and always reads 00h.
- R11: While a write is running, bus writes to the address and data registers are ignored.
- R12: The erase phase comes first. So a write cut short by warm reset leaves the target byte at FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Warm reset, synchronous, active high |
| por | input | 1 | Power-on reset, synchronous, active high, also clears write-error |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| pm_en | output | 1 | Program store read enable |
| pm_addr | output | 13 | Program store word address |
| pm_data | input | 14 | Program store word, valid the cycle after `pm_en` |
| irq | output | 1 | Write-done flag |

## Verification
The assertions check the following on every cycle:
- every rise of write-go follows an armed key, a set permit bit and a go write;
- no array write happens while program-select is set;
- write-go stays up for exactly the timer length;
- completion raises `irq`;
- a warm reset during a write leaves the error bit and cleared registers;
- data-array reads are single-cycle.

Only the directed scenarios can show the effects that depend on stored data:
- the erase-to-FFh left by an aborted write;
- the stored byte after a full write;
- ignored address and data writes while busy;
- the program word captured across both data registers;
- software clears of the sticky flags.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    typedef enum logic [2:0] {
        REG_ADR_LO = 3'd0,
        REG_ADR_HI = 3'd1,
        REG_DAT_LO = 3'd2,
        REG_DAT_HI = 3'd3,
        REG_CTRL   = 3'd4,
        REG_KEY    = 3'd5
    } reg_sel_e;

    localparam int BIT_RD   = 0;
    localparam int BIT_WR   = 1;
    localparam int BIT_WEN  = 2;
    localparam int BIT_ERR  = 3;
    localparam int BIT_DONE = 4;
    localparam int BIT_PSEL = 7;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;
    localparam logic [7:0] ERASED     = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DATA,
        ST_RD_PISSUE,
        ST_RD_PCAP,
        ST_WRITE
    } op_state_e;

    typedef enum logic [1:0] {
        KEY_NONE,
        KEY_HALF,
        KEY_FULL
    } key_stage_e;

    typedef struct packed {
        logic psel;
        logic done;
        logic err;
        logic wen;
    } ctrl_t;

    function automatic logic [7:0] pack_ctrl(ctrl_t c, logic rd_go, logic wr_go);
        logic [7:0] v;
        v           = 8'h00;
        v[BIT_RD]   = rd_go;
        v[BIT_WR]   = wr_go;
        v[BIT_WEN]  = c.wen;
        v[BIT_ERR]  = c.err;
        v[BIT_DONE] = c.done;
        v[BIT_PSEL] = c.psel;
        return v;
    endfunction

endpackage

// File: rtl/nvm_key_seq.sv
module nvm_key_seq
    import nvm_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  logic       wr_stb,
    input  logic       hit_key,
    input  logic [7:0] wdata,
    output logic       armed
);
    key_stage_e stage;

    always_ff @(posedge clk) begin
        if (clr) begin
            stage <= KEY_NONE;
        end else if (wr_stb) begin
            if (hit_key && wdata == KEY_FIRST)
                stage <= KEY_HALF;
            else if (hit_key && wdata == KEY_SECOND && stage == KEY_HALF)
                stage <= KEY_FULL;
            else
                stage <= KEY_NONE;
        end
    end

    assign armed = (stage == KEY_FULL);
endmodule

// File: rtl/nvm_wr_timer.sv
module nvm_wr_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic clr,
    input  logic run,
    output logic at_first,
    output logic at_last
);
    localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clr || !run)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign at_first = run && (cnt == '0);
    assign at_last  = run && (cnt == LAST);
endmodule

// File: rtl/nvm_data_array.sv
module nvm_data_array #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            cells[addr] <= wdata;
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/nvm_access_ctrl.sv
module nvm_access_ctrl
    import nvm_pkg::*;
#(
    parameter int DATA_AW   = 8,
    parameter int PROG_AW   = 13,
    parameter int PROG_DW   = 14,
    parameter int WR_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               por,
    input  logic               reg_wr,
    input  logic [2:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    output logic               pm_en,
    output logic [PROG_AW-1:0] pm_addr,
    input  logic [PROG_DW-1:0] pm_data,
    output logic               irq
);
    localparam int HI_AW = PROG_AW - 8;
    localparam int HI_DW = PROG_DW - 8;

    logic             rst_any;
    logic [7:0]       adr_lo;
    logic [HI_AW-1:0] adr_hi;
    logic [7:0]       dat_lo;
    logic [HI_DW-1:0] dat_hi;
    ctrl_t            cq;
    op_state_e        st;

    logic wr_ctrl, busy, idle, psel_nx, rd_req, wr_req;
    logic key_armed, tmr_first, tmr_last;
    logic mem_we;
    logic [7:0] mem_wdata, mem_rdata;
    logic rd_go, wr_go;

    assign rst_any = rst | por;
    assign busy    = (st == ST_WRITE);
    assign idle    = (st == ST_IDLE);
    assign wr_ctrl = reg_wr && (reg_addr == REG_CTRL);
    assign psel_nx = idle ? reg_wdata[BIT_PSEL] : cq.psel;
    assign wr_req  = wr_ctrl && reg_wdata[BIT_WR] && idle && cq.wen && key_armed && !psel_nx;
    assign rd_req  = wr_ctrl && reg_wdata[BIT_RD] && idle && !wr_req;

    nvm_key_seq u_key (
        .clk    (clk),
        .clr    (rst_any),
        .wr_stb (reg_wr),
        .hit_key(reg_addr == REG_KEY),
        .wdata  (reg_wdata),
        .armed  (key_armed)
    );

    nvm_wr_timer #(.CYCLES(WR_CYCLES)) u_tmr (
        .clk     (clk),
        .clr     (rst_any),
        .run     (busy),
        .at_first(tmr_first),
        .at_last (tmr_last)
    );

    assign mem_we    = busy && (tmr_first || tmr_last);
    assign mem_wdata = tmr_last ? dat_lo : ERASED;

    nvm_data_array #(.AW(DATA_AW), .DW(8)) u_arr (
        .clk  (clk),
        .we   (mem_we),
        .addr (adr_lo[DATA_AW-1:0]),
        .wdata(mem_wdata),
        .rdata(mem_rdata)
    );

    // operation sequencer
    always_ff @(posedge clk) begin
        if (rst_any) begin
            st <= ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (wr_req)
                        st <= ST_WRITE;
                    else if (rd_req)
                        st <= psel_nx ? ST_RD_PISSUE : ST_RD_DATA;
                end
                ST_RD_DATA:   st <= ST_IDLE;
                ST_RD_PISSUE: st <= ST_RD_PCAP;
                ST_RD_PCAP:   st <= ST_IDLE;
                ST_WRITE:     if (tmr_last) st <= ST_IDLE;
                default:      st <= ST_IDLE;
            endcase
        end
    end

    // register file
    always_ff @(posedge clk) begin
        if (rst_any) begin
            adr_lo  <= '0;
            adr_hi  <= '0;
            dat_lo  <= '0;
            dat_hi  <= '0;
            cq.psel <= 1'b0;
            cq.done <= 1'b0;
            cq.wen  <= 1'b0;
            cq.err  <= por ? 1'b0 : (cq.err | busy);
        end else begin
            if (reg_wr && !busy) begin
                unique case (reg_addr)
                    REG_ADR_LO: adr_lo <= reg_wdata;
                    REG_ADR_HI: adr_hi <= reg_wdata[HI_AW-1:0];
                    REG_DAT_LO: dat_lo <= reg_wdata;
                    REG_DAT_HI: dat_hi <= reg_wdata[HI_DW-1:0];
                    default: ;
                endcase
            end
            if (wr_ctrl) begin
                cq.wen  <= reg_wdata[BIT_WEN];
                cq.err  <= cq.err  & reg_wdata[BIT_ERR];
                cq.done <= cq.done & reg_wdata[BIT_DONE];
                cq.psel <= psel_nx;
            end
            if (st == ST_RD_DATA)
                dat_lo <= mem_rdata;
            if (st == ST_RD_PCAP) begin
                dat_lo <= pm_data[7:0];
                dat_hi <= pm_data[PROG_DW-1:8];
            end
            if (busy && tmr_last)
                cq.done <= 1'b1;
        end
    end

    assign rd_go   = (st == ST_RD_DATA) || (st == ST_RD_PISSUE) || (st == ST_RD_PCAP);
    assign wr_go   = busy;
    assign pm_en   = (st == ST_RD_PISSUE);
    assign pm_addr = {adr_hi, adr_lo};
    assign irq     = cq.done;

    always_comb begin
        unique case (reg_addr)
            REG_ADR_LO: reg_rdata = adr_lo;
            REG_ADR_HI: reg_rdata = 8'(adr_hi);
            REG_DAT_LO: reg_rdata = dat_lo;
            REG_DAT_HI: reg_rdata = 8'(dat_hi);
            REG_CTRL:   reg_rdata = pack_ctrl(cq, rd_go, wr_go);
            default:    reg_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/nvm_access_ctrl_chk.sv
module nvm_access_ctrl_chk #(
    parameter int WR_CYCLES = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       por,
    input logic       reg_wr,
    input logic [2:0] reg_addr,
    input logic       go_bit,
    input logic       rd_go,
    input logic       wr_go,
    input logic       psel,
    input logic       wen,
    input logic       armed,
    input logic       err,
    input logic       irq,
    input logic       mem_we,
    input logic [7:0] adr_lo,
    input logic [7:0] dat_lo
);
    int run_cnt;

    always_ff @(posedge clk) begin
        if (rst || por || !wr_go)
            run_cnt <= 0;
        else
            run_cnt <= run_cnt + 1;
    end

    a_r6_write_gated: assert property (@(posedge clk) disable iff (rst || por)
        $rose(wr_go) |-> $past(armed && wen && reg_wr && reg_addr == 3'd4 && go_bit));

    a_r4_prog_never_written: assert property (@(posedge clk) disable iff (rst || por)
        mem_we |-> !psel);

    a_r2_data_read_single: assert property (@(posedge clk) disable iff (rst || por)
        ($rose(rd_go) && !psel) |=> !rd_go);

    a_r7_timer_bound: assert property (@(posedge clk) disable iff (rst || por)
        wr_go |-> run_cnt < WR_CYCLES);

    a_r7_full_length: assert property (@(posedge clk) disable iff (rst || por)
        ($fell(wr_go) && !$past(rst || por)) |-> $past(run_cnt) == WR_CYCLES - 1);

    a_r8_done_on_finish: assert property (@(posedge clk) disable iff (rst || por)
        ($fell(wr_go) && !$past(rst || por)) |-> irq);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (por)
        ($past(rst) && $past(wr_go)) |-> err);

    a_r9_regs_cleared: assert property (@(posedge clk) disable iff (por)
        $past(rst) |-> (adr_lo == 8'h00 && dat_lo == 8'h00));
endmodule

bind nvm_access_ctrl nvm_access_ctrl_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .por     (por),
    .reg_wr  (reg_wr),
    .reg_addr(reg_addr),
    .go_bit  (reg_wdata[1]),
    .rd_go   (rd_go),
    .wr_go   (wr_go),
    .psel    (cq.psel),
    .wen     (cq.wen),
    .armed   (key_armed),
    .err     (cq.err),
    .irq     (irq),
    .mem_we  (mem_we),
    .adr_lo  (adr_lo),
    .dat_lo  (dat_lo)
);

// File: tb/sim_nvm_access_ctrl.sv
module sim_nvm_access_ctrl;
    localparam int WRC = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        por = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        pm_en;
    logic [12:0] pm_addr;
    logic [13:0] pm_data = 14'h0;
    logic        irq;

    int total = 0;
    int bad = 0;

    nvm_access_ctrl #(.WR_CYCLES(WRC)) u0 (
        .clk(clk), .rst(rst), .por(por), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pm_en(pm_en),
        .pm_addr(pm_addr), .pm_data(pm_data), .irq(irq)
    );

    always #5 clk = ~clk;

    function automatic logic [13:0] rom_word(logic [12:0] a);
        return 14'((a * 5) ^ 14'h2A55);
    endfunction

    always @(posedge clk) if (pm_en) pm_data <= rom_word(pm_addr);

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [2:0] a, logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [2:0] a, output logic [7:0] v);
        reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic data_read(logic [7:0] a, output logic [7:0] v);
        logic [7:0] c;
        bus_wr(3'd0, a);
        bus_wr(3'd4, 8'h1D);
        rd_reg(3'd4, c);
        chk("R2 read-go up", 16'(c[0]), 16'h1);
        @(negedge clk);
        rd_reg(3'd4, c);
        chk("R2 read-go cleared", 16'(c[0]), 16'h0);
        rd_reg(3'd2, v);
    endtask

    task automatic start_write(logic [7:0] a, logic [7:0] d, logic [7:0] go);
        bus_wr(3'd0, a);
        bus_wr(3'd2, d);
        bus_wr(3'd4, 8'h1C);
        bus_wr(3'd5, 8'h55);
        bus_wr(3'd5, 8'hAA);
        bus_wr(3'd4, go);
    endtask

    task automatic wait_idle();
        logic [7:0] c;
        for (int i = 0; i < 4 * WRC; i++) begin
            rd_reg(3'd4, c);
            if (!c[1]) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int r = 0; r < 6; r++) begin
            rd_reg(3'(r), v);
            chk("R1 reset register", 16'(v), 16'h0);
        end
        chk("R1 irq low", 16'(irq), 16'h0);
    endtask

    task automatic t_reg_widths();
        logic [7:0] v;
        bus_wr(3'd1, 8'hFF);
        rd_reg(3'd1, v); chk("R2 adr-hi width", 16'(v), 16'h1F);
        bus_wr(3'd3, 8'hFF);
        rd_reg(3'd3, v); chk("R2 dat-hi width", 16'(v), 16'h3F);
        bus_wr(3'd5, 8'h55);
        rd_reg(3'd5, v); chk("R10 key reads zero", 16'(v), 16'h0);
    endtask

    task automatic t_write_timing(logic [7:0] a, logic [7:0] d);
        logic [7:0] c, v;
        start_write(a, d, 8'h1E);
        rd_reg(3'd4, c); chk("R7 write-go set", 16'(c[1]), 16'h1);
        repeat (WRC - 1) @(negedge clk);
        rd_reg(3'd4, c); chk("R7 still busy at N-1", 16'(c[1]), 16'h1);
        @(negedge clk);
        rd_reg(3'd4, c); chk("R7 done after N", 16'(c[1]), 16'h0);
        chk("R8 irq set", 16'(irq), 16'h1);
        data_read(a, v);
        chk("R7 stored byte", 16'(v), 16'(d));
    endtask

    task automatic t_locks();
        logic [7:0] c;
        bus_wr(3'd4, 8'h1C);
        bus_wr(3'd4, 8'h1E);
        rd_reg(3'd4, c); chk("R6 no key rejected", 16'(c[1]), 16'h0);
        bus_wr(3'd5, 8'h55);
        bus_wr(3'd0, 8'h10);
        bus_wr(3'd5, 8'hAA);
        bus_wr(3'd4, 8'h1E);
        rd_reg(3'd4, c); chk("R6 broken key rejected", 16'(c[1]), 16'h0);
        bus_wr(3'd4, 8'h18);
        bus_wr(3'd5, 8'h55);
        bus_wr(3'd5, 8'hAA);
        bus_wr(3'd4, 8'h1A);
        rd_reg(3'd4, c); chk("R6 permit clear rejected", 16'(c[1]), 16'h0);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] c, v;
        start_write(8'h40, 8'h3C, 8'h1E);
        bus_wr(3'd4, 8'h1C);
        rd_reg(3'd4, c); chk("R5 sw zero keeps write-go", 16'(c[1]), 16'h1);
        bus_wr(3'd0, 8'h41);
        bus_wr(3'd2, 8'h99);
        rd_reg(3'd0, v); chk("R11 adr-lo held", 16'(v), 16'h40);
        rd_reg(3'd2, v); chk("R11 dat-lo held", 16'(v), 16'h3C);
        wait_idle();
        data_read(8'h40, v);
        chk("R11 stored original", 16'(v), 16'h3C);
    endtask

    task automatic t_prog_read();
        logic [7:0] c, v;
        logic [13:0] w;
        w = rom_word(13'h153C);
        bus_wr(3'd1, 8'h15);
        bus_wr(3'd0, 8'h3C);
        bus_wr(3'd4, 8'h9D);
        chk("R3 pm_en pulse", 16'(pm_en), 16'h1);
        chk("R3 pm_addr", 16'(pm_addr), 16'h153C);
        @(negedge clk);
        chk("R3 pm_en single", 16'(pm_en), 16'h0);
        rd_reg(3'd4, c); chk("R3 read-go second cycle", 16'(c[0]), 16'h1);
        bus_wr(3'd4, 8'h9C);
        rd_reg(3'd4, c); chk("R5 read-go cleared by hw", 16'(c[0]), 16'h0);
        rd_reg(3'd2, v); chk("R3 data-lo", 16'(v), 16'(w[7:0]));
        rd_reg(3'd3, v); chk("R3 data-hi", 16'(v), 16'(w[13:8]));
    endtask

    task automatic t_prog_write();
        logic [7:0] c, v;
        bus_wr(3'd0, 8'h40);
        bus_wr(3'd2, 8'h77);
        bus_wr(3'd4, 8'h9C);
        bus_wr(3'd5, 8'h55);
        bus_wr(3'd5, 8'hAA);
        bus_wr(3'd4, 8'h9E);
        rd_reg(3'd4, c); chk("R4 program write refused", 16'(c[1]), 16'h0);
        repeat (WRC + 2) @(negedge clk);
        bus_wr(3'd4, 8'h1C);
        data_read(8'h40, v);
        chk("R4 data unchanged", 16'(v), 16'h3C);
    endtask

    task automatic t_done_clear();
        bus_wr(3'd4, 8'h0C);
        chk("R8 sw clear", 16'(irq), 16'h0);
        bus_wr(3'd4, 8'h1C);
        chk("R8 sw cannot set", 16'(irq), 16'h0);
    endtask

    task automatic t_abort();
        logic [7:0] c, v;
        start_write(8'h22, 8'h5A, 8'h1E);
        repeat (4) @(negedge clk);
        rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
        rd_reg(3'd4, c);
        chk("R9 error set", 16'(c[3]), 16'h1);
        chk("R9 write-go cleared", 16'(c[1]), 16'h0);
        rd_reg(3'd0, v); chk("R9 adr-lo cleared", 16'(v), 16'h0);
        rd_reg(3'd2, v); chk("R9 dat-lo cleared", 16'(v), 16'h0);
        rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
        rd_reg(3'd4, c); chk("R9 error survives warm reset", 16'(c[3]), 16'h1);
        data_read(8'h22, v);
        chk("R12 aborted byte erased", 16'(v), 16'hFF);
        bus_wr(3'd4, 8'h14);
        rd_reg(3'd4, c); chk("R9 sw clear error", 16'(c[3]), 16'h0);
        start_write(8'h23, 8'h11, 8'h1E);
        repeat (3) @(negedge clk);
        rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
        por = 1'b1; @(posedge clk); @(negedge clk); por = 1'b0;
        rd_reg(3'd4, c); chk("R9 por clears error", 16'(c), 16'h0);
    endtask

    initial begin
        #(200000 * 10);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0; por = 1'b0;
        @(negedge clk);
        t_reset();
        t_reg_widths();
        t_write_timing(8'h05, 8'hA7);
        t_write_timing(8'hFF, 8'h00);
        t_locks();
        t_busy_ignore();
        t_prog_read();
        t_prog_write();
        t_done_clear();
        t_abort();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule